// File: doc/BRIEF.md
# PCM Telemetry Frame Formatter

This block assembles fixed-format, time-division PCM telemetry frames and sends them out as one serial bit stream. Every frame opens with a 16-bit synchronization word and is followed by a fixed number of 8-bit data slots. Each slot has a kind that is fixed at build time. An analog slot carries a converted sample of one multiplexer input. An external-digital slot carries a parallel word that is taken in at the moment its slot begins. A window slot carries bytes of asynchronous block data, which carry their own group framing, from a small buffer.

While one word is being shifted out, the block drives the address of the multiplexer input that the next slot needs. It takes in converter samples that arrive with a valid strobe during that word. The serial output advances one bit every `BIT_DIV` clocks, sending the most significant bit first. A bit strobe marks each new bit and a frame pulse marks the first sync bit. Frames follow one another with no gap, so the timing of every slot is fixed once the parameters are chosen.

Top module: `tlm_pcm_framer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ser_data`, `bit_stb` and `frame_start` are 0 and `mux_addr` is 0.
- R2: A new bit appears on `ser_data` every `BIT_DIV` clock cycles, and `bit_stb` is high for exactly the first cycle of each bit. A frame is `SYNC_W + NUM_SLOTS*WORD_W` bits long (64 by default), and frames are sent back to back. Every word is sent most significant bit first.
- R3: Each frame begins with the sync word `SYNC_PATTERN` (0xEB90 by default). `frame_start` is high together with `bit_stb` on the first sync bit only.
- R4: Frame words are numbered w = 0 for the sync word, and slot s is word s+1. During word w, `mux_addr` equals w when w < `NUM_SLOTS` and 0 otherwise. It changes only in a cycle where `bit_stb` is high.
- R5: An analog slot s carries the last `smp_data` presented with `smp_valid` high while `mux_addr` equaled s. A sample in the cycle the slot is loaded counts. If no valid sample arrived in that word, the slot carries 0x00.
- R6: The external-digital slot (bit s of `EXT_MASK` set; slot 3 by default) carries the value of `ext_word` in the cycle the slot is loaded. Later changes do not affect that frame.
- R7: A window slot (bit s of `WIN_MASK` set and clear in `EXT_MASK`; slot 5 by default) carries the oldest buffered block byte and removes it from the buffer. When the buffer is empty, the slot carries 0xAA.
- R8: The block buffer holds `BLK_DEPTH` bytes (4 by default). A `blk_valid` byte that arrives while the buffer is full is discarded.
- R9: If `blk_valid` coincides with the loading of a window slot, both decisions use the buffer occupancy before that cycle. If the buffer was empty, the slot carries 0xAA and the byte is kept. If it was full, one byte is sent and the new byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | WORD_W | Converted sample for the addressed multiplexer input |
| smp_valid | input | 1 | Qualifies smp_data |
| ext_word | input | WORD_W | External digital parameter, taken in when its slot starts |
| blk_data | input | WORD_W | Asynchronous block-data byte |
| blk_valid | input | 1 | Writes blk_data into the window buffer |
| mux_addr | output | ADDR_W | Multiplexer input for the upcoming slot |
| ser_data | output | 1 | Serial frame bit stream |
| bit_stb | output | 1 | High on the first cycle of each serial bit |
| frame_start | output | 1 | High on the first bit of each sync word |

## Verification
The buffer write and the window-slot read can fall in the same cycle. The bench counts cycles from the frame pulse and raises `blk_valid` exactly in the cycle that loads the window slot. It does this once with an empty buffer and once with a full one. The scoreboard model applies both decisions to the occupancy before that cycle. It expects 0xAA and a kept byte in the first case, and one byte sent and the new byte discarded in the second. Later frames show whether the buffer contents came out in the order the model predicts.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
  typedef enum logic [1:0] {
    SLOT_ANALOG = 2'd0,
    SLOT_EXT    = 2'd1,
    SLOT_WIN    = 2'd2
  } slot_kind_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tfb_bit_timer.sv
module tfb_bit_timer #(
  parameter int BIT_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bit_tick
);
  generate
    if (BIT_DIV <= 1) begin : g_full_rate
      assign bit_tick = 1'b1;
    end else begin : g_divided
      localparam int CNT_W = $clog2(BIT_DIV);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_W'(BIT_DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign bit_tick = (cnt_q == CNT_W'(BIT_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/tfb_slot_seq.sv
module tfb_slot_seq #(
  parameter int NUM_SLOTS = 6,
  parameter int SYNC_W    = 16,
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int WIDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  output logic              word_end,
  output logic [WIDX_W-1:0] next_idx,
  output logic [ADDR_W-1:0] mux_addr
);
  localparam int MAX_W  = tfb_pkg::max_int(SYNC_W, WORD_W);
  localparam int BIDX_W = $clog2(MAX_W);

  logic [BIDX_W-1:0] bit_q;
  logic [WIDX_W-1:0] word_q;
  logic [BIDX_W-1:0] last_bit;

  assign last_bit = (word_q == '0) ? BIDX_W'(SYNC_W - 1) : BIDX_W'(WORD_W - 1);
  assign word_end = bit_tick && (bit_q == last_bit);
  assign next_idx = (word_q == WIDX_W'(NUM_SLOTS)) ? '0 : word_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= BIDX_W'(WORD_W - 1);
      word_q   <= WIDX_W'(NUM_SLOTS);
      mux_addr <= '0;
    end else if (word_end) begin
      bit_q    <= '0;
      word_q   <= next_idx;
      mux_addr <= (next_idx < WIDX_W'(NUM_SLOTS)) ? ADDR_W'(next_idx) : '0;
    end else if (bit_tick) begin
      bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/tfb_win_fifo.sv
module tfb_win_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign push_ok = push && (cnt_q < CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) begin
        wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (pop_ok) begin
        rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/tfb_shifter.sv
module tfb_shifter #(
  parameter int SH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [SH_W-1:0] load_val,
  output logic            ser
);
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift) begin
      sh_q <= sh_q << 1;
    end
  end

  assign ser = sh_q[SH_W-1];
endmodule

// File: rtl/tlm_pcm_framer.sv
module tlm_pcm_framer #(
  parameter int                    WORD_W       = 8,
  parameter int                    SYNC_W       = 16,
  parameter logic [SYNC_W-1:0]     SYNC_PATTERN = 16'hEB90,
  parameter int                    NUM_SLOTS    = 6,
  parameter int                    ADDR_W       = 4,
  parameter int                    BIT_DIV      = 2,
  parameter int                    BLK_DEPTH    = 4,
  parameter logic [WORD_W-1:0]     FILL_BYTE    = 8'hAA,
  parameter logic [NUM_SLOTS-1:0]  EXT_MASK     = 6'b001000,
  parameter logic [NUM_SLOTS-1:0]  WIN_MASK     = 6'b100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] ext_word,
  input  logic [WORD_W-1:0] blk_data,
  input  logic              blk_valid,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              ser_data,
  output logic              bit_stb,
  output logic              frame_start
);
  import tfb_pkg::*;

  localparam int WIDX_W = $clog2(NUM_SLOTS + 1);
  localparam int SH_W   = max_int(SYNC_W, WORD_W);
  localparam int KIND_N = 2 ** WIDX_W;

  logic              bit_tick;
  logic              word_end;
  logic [WIDX_W-1:0] next_idx;
  logic [WIDX_W-1:0] slot_sel;
  slot_kind_e        kind_tab [KIND_N];
  slot_kind_e        next_kind;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] analog_val;
  logic [WORD_W-1:0] fifo_dout;
  logic              fifo_empty;
  logic              win_pop;
  logic [WORD_W-1:0] slot_val;
  logic [SH_W-1:0]   load_word;

  generate
    for (genvar s = 0; s < KIND_N; s++) begin : g_kind
      if (s < NUM_SLOTS) begin : g_used
        assign kind_tab[s] = EXT_MASK[s] ? SLOT_EXT :
                             WIN_MASK[s] ? SLOT_WIN : SLOT_ANALOG;
      end else begin : g_unused
        assign kind_tab[s] = SLOT_ANALOG;
      end
    end
  endgenerate

  tfb_bit_timer #(.BIT_DIV(BIT_DIV)) timer_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick)
  );

  tfb_slot_seq #(
    .NUM_SLOTS(NUM_SLOTS), .SYNC_W(SYNC_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .WIDX_W(WIDX_W)
  ) seq_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .word_end(word_end),
    .next_idx(next_idx), .mux_addr(mux_addr)
  );

  assign slot_sel  = next_idx - 1'b1;
  assign next_kind = kind_tab[slot_sel];

  // sample holding register: cleared at every word load, refilled by valid samples
  always_ff @(posedge clk) begin
    if (rst || word_end) begin
      hold_q <= '0;
    end else if (smp_valid) begin
      hold_q <= smp_data;
    end
  end

  assign analog_val = smp_valid ? smp_data : hold_q;
  assign win_pop    = word_end && (next_idx != '0) && (next_kind == SLOT_WIN) && !fifo_empty;

  tfb_win_fifo #(.DEPTH(BLK_DEPTH), .W(WORD_W)) fifo_i (
    .clk(clk), .rst(rst), .push(blk_valid), .din(blk_data),
    .pop(win_pop), .dout(fifo_dout), .empty(fifo_empty)
  );

  always_comb begin
    unique case (next_kind)
      SLOT_EXT:    slot_val = ext_word;
      SLOT_WIN:    slot_val = fifo_empty ? FILL_BYTE : fifo_dout;
      default:     slot_val = analog_val;
    endcase
    if (next_idx == '0) begin
      load_word = SH_W'(SYNC_PATTERN) << (SH_W - SYNC_W);
    end else begin
      load_word = SH_W'(slot_val) << (SH_W - WORD_W);
    end
  end

  tfb_shifter #(.SH_W(SH_W)) shift_i (
    .clk(clk), .rst(rst), .load(word_end), .shift(bit_tick),
    .load_val(load_word), .ser(ser_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_stb     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      bit_stb     <= bit_tick;
      frame_start <= word_end && (next_idx == '0);
    end
  end
endmodule

// File: rtl/tfb_checker.sv
module tfb_checker #(
  parameter int                ADDR_W       = 4,
  parameter int                NUM_SLOTS    = 6,
  parameter int                BIT_DIV      = 2,
  parameter int                SYNC_W       = 16,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 16'hEB90
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mux_addr,
  input logic              ser_data,
  input logic              bit_stb,
  input logic              frame_start
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (bit_stb) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bit_stb && !frame_start && !ser_data && mux_addr == '0)); // R1

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && seen_q) |-> (gap_q == 32'(BIT_DIV - 1))); // R2

  AST_FRAME_ON_STB: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> bit_stb); // R3

  AST_SYNC_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (ser_data == SYNC_PATTERN[SYNC_W-1])); // R3

  AST_ADDR_ON_STB: assert property (@(posedge clk) disable iff (rst)
    (mux_addr != $past(mux_addr)) |-> bit_stb); // R4

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    mux_addr < ADDR_W'(NUM_SLOTS)); // R4
endmodule

bind tlm_pcm_framer tfb_checker #(
  .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .BIT_DIV(BIT_DIV),
  .SYNC_W(SYNC_W), .SYNC_PATTERN(SYNC_PATTERN)
) chk_i (
  .clk(clk), .rst(rst), .mux_addr(mux_addr), .ser_data(ser_data),
  .bit_stb(bit_stb), .frame_start(frame_start)
);

// File: tb/tlm_pcm_framer_tb_top.sv
`timescale 1ns/1ps
module tlm_pcm_framer_tb_top;
  localparam int WORD_W    = 8;
  localparam int SYNC_W    = 16;
  localparam int NUM_SLOTS = 6;
  localparam int ADDR_W    = 4;
  localparam int BIT_DIV   = 2;
  localparam int DEPTH     = 4;
  localparam int FB        = SYNC_W + NUM_SLOTS * WORD_W;
  localparam int EXT_SLOT  = 3;
  localparam int WIN_SLOT  = 5;
  localparam int EXT_LOAD  = (SYNC_W + EXT_SLOT * WORD_W) * BIT_DIV;
  localparam int WIN_LOAD  = (SYNC_W + WIN_SLOT * WORD_W) * BIT_DIV;
  localparam int N_FRAMES  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WORD_W-1:0] smp_data = '0;
  logic smp_valid = 1'b0;
  logic [WORD_W-1:0] ext_word = '0;
  logic [WORD_W-1:0] blk_data = '0;
  logic blk_valid = 1'b0;
  logic [ADDR_W-1:0] mux_addr;
  logic ser_data, bit_stb, frame_start;

  always #2 clk = ~clk;

  tlm_pcm_framer #(
    .WORD_W(WORD_W), .SYNC_W(SYNC_W), .SYNC_PATTERN(16'hEB90),
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BIT_DIV(BIT_DIV),
    .BLK_DEPTH(DEPTH), .FILL_BYTE(8'hAA),
    .EXT_MASK(6'b001000), .WIN_MASK(6'b100000)
  ) dut_i (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .ext_word(ext_word), .blk_data(blk_data), .blk_valid(blk_valid),
    .mux_addr(mux_addr), .ser_data(ser_data), .bit_stb(bit_stb),
    .frame_start(frame_start)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [WORD_W-1:0] smp_base = '0;
  logic [FB-1:0] exp_q [$];
  string         wtag_q [$];
  logic [7:0]    model_q [$];
  logic [7:0]    pend [$];
  int frames_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // sample source: value depends on the address currently shown
  always @(negedge clk) smp_data <= smp_base + 8'(mux_addr) * 8'h11;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: collects frame bits and compares against the scoreboard
  bit in_frame = 1'b0;
  int pos = 0;
  int last_stb = -1;
  logic [FB-1:0] cur = '0;
  always @(negedge clk) begin
    if (!rst && bit_stb) begin
      if (last_stb >= 0) chk("R2 bit period", cyc - last_stb, BIT_DIV);
      last_stb = cyc;
      if (!in_frame && frame_start) begin
        in_frame = 1'b1;
        pos = 0;
      end
      if (in_frame) begin
        int w;
        chk("R3 frame_start position", 32'(frame_start), 32'(pos == 0));
        w = -1;
        if (pos == 0) w = 0;
        else if (pos >= SYNC_W && ((pos - SYNC_W) % WORD_W) == 0) w = (pos - SYNC_W) / WORD_W + 1;
        if (w >= 0) chk("R4 mux_addr", 32'(mux_addr), (w < NUM_SLOTS) ? w : 0);
        cur = {cur[FB-2:0], ser_data};
        pos++;
        if (pos == FB) begin
          logic [FB-1:0] e;
          string wt;
          pos = 0;
          frames_done++;
          if (exp_q.size() == 0) begin
            chk("R2 scoreboard underrun", 1, 0);
          end else begin
            e  = exp_q.pop_front();
            wt = wtag_q.pop_front();
            chk("R3 sync word", 32'(cur[FB-1 -: SYNC_W]), 32'(e[FB-1 -: SYNC_W]));
            for (int s = 0; s < NUM_SLOTS; s++) begin
              string tg;
              tg = (s == EXT_SLOT) ? "R6 ext slot" : (s == WIN_SLOT) ? wt : "R5 analog slot";
              chk(tg, 32'(cur[FB-1-SYNC_W-WORD_W*s -: WORD_W]),
                      32'(e[FB-1-SYNC_W-WORD_W*s -: WORD_W]));
            end
          end
        end
      end
    end
  end

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push_blk(input logic [7:0] v);
    @(negedge clk);
    blk_data  = v;
    blk_valid = 1'b1;
    @(negedge clk);
    blk_valid = 1'b0;
    if (model_q.size() < DEPTH) model_q.push_back(v); // R8: drop when full
  endtask

  // driver: sets stimulus for one frame and queues the expected frame
  task automatic run_frame(input logic [7:0] base, input bit von, input logic [7:0] ext0,
                           input bit late_ext, input logic [7:0] ext1,
                           input bit simp, input logic [7:0] simv, input string wtag);
    int c0, pre;
    logic [7:0] win;
    logic [FB-1:0] e;
    wait_frame();
    c0 = cyc;
    smp_base  = base;
    smp_valid = von;
    ext_word  = ext0;
    foreach (pend[i]) push_blk(pend[i]);
    pend.delete();
    pre = model_q.size();
    win = (pre > 0) ? model_q.pop_front() : 8'hAA;
    if (simp && pre < DEPTH) model_q.push_back(simv); // R9: occupancy before the cycle
    e = '0;
    e[FB-1 -: SYNC_W] = 16'hEB90;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      logic [7:0] v;
      if (s == EXT_SLOT) v = ext0;
      else if (s == WIN_SLOT) v = win;
      else v = von ? 8'(base + 8'(s) * 8'h11) : 8'h00;
      e[FB-1-SYNC_W-WORD_W*s -: WORD_W] = v;
    end
    exp_q.push_back(e);
    wtag_q.push_back(wtag);
    if (late_ext) begin
      wait_cyc(c0 + EXT_LOAD + 10);
      ext_word = ext1;
    end
    if (simp) begin
      wait_cyc(c0 + WIN_LOAD - 1);
      blk_data  = simv;
      blk_valid = 1'b1;
      @(negedge clk);
      blk_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset ser_data", 32'(ser_data), 0);
    chk("R1 reset frame_start", 32'(frame_start), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ser_data", 32'(ser_data), 0);
    chk("R1 bit_stb", 32'(bit_stb), 0);
    chk("R1 frame_start", 32'(frame_start), 0);
    chk("R1 mux_addr", 32'(mux_addr), 0);

    pend.delete();
    run_frame(8'h10, 1, 8'h3C, 0, 8'h00, 0, 8'h00, "R7 empty window fill");
    pend = {8'h11, 8'h22};
    run_frame(8'h00, 0, 8'hC3, 0, 8'h00, 0, 8'h00, "R7 window oldest byte");
    run_frame(8'h80, 1, 8'h5A, 1, 8'hFF, 0, 8'h00, "R7 window second byte");
    run_frame(8'h20, 1, 8'h01, 0, 8'h00, 1, 8'h77, "R9 push on empty load");
    pend = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35};
    run_frame(8'h40, 1, 8'h02, 0, 8'h00, 0, 8'h00, "R9 kept byte sent");
    pend = {8'h36};
    run_frame(8'h50, 0, 8'h03, 0, 8'h00, 1, 8'h99, "R9 push on full load");
    run_frame(8'h60, 1, 8'h04, 0, 8'h00, 0, 8'h00, "R8 order after overflow");
    run_frame(8'h70, 1, 8'h05, 0, 8'h00, 0, 8'h00, "R8 order after overflow");
    run_frame(8'h90, 0, 8'h06, 0, 8'h00, 0, 8'h00, "R8 last kept byte");
    run_frame(8'hA0, 1, 8'h07, 0, 8'h00, 0, 8'h00, "R8 drained to fill");
    while (frames_done < N_FRAMES) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule